// File: doc/BRIEF.md
# Convolution Loop-Nest Address Sequencer

This block drives the operand fetch for one convolution layer. After a start pulse it captures the layer settings: the mode, the channel counts, the number of spatial blocks, the kernel size, the dilation rate, the strides and a weight base. It then walks the loop nest and issues one kernel tap per cycle. For each tap it gives a feature-map address and a weight address, plus framing flags that tell the multiply-accumulate array where each kernel window and each accumulation starts and ends.

Regular mode runs three loop levels. Output channel is the outermost level, then spatial block, then input channel, with the kernel taps innermost. Depthwise mode has no input-channel level, because each channel only feeds itself. That mode runs channel, then block, then taps, so no zero-weight taps are ever issued. The block handles one layer per start. A one-cycle done pulse closes the layer.

Top module: `conv_seq`

## Requirements
- R1: After reset, busy, tap_vld, tap_first, tap_last, acc_last and done are 0. A start seen while busy is 0 is accepted, and busy is 1 from the next cycle. The first tap shows on tap_vld in the second cycle after the start cycle.
- R2: In regular mode (mode=0), taps are issued in this loop order, outermost first: output channel 0..n_out_m1, spatial block 0..n_blk_m1, input channel 0..n_in_m1, kernel row ky 0..k_m1, kernel column kx 0..k_m1. The column index changes fastest.
- R3: In depthwise mode (mode=1), taps are issued in this order, outermost first: channel 0..n_out_m1, block, ky, kx. The input n_in_m1 has no effect.
- R4: fm_addr = ch*ch_stride + blk*blk_stride + d*ky*row_stride + d*kx, taken modulo 2^FA_W. Here d = dil_m1+1. In regular mode ch is the input channel; in depthwise mode it is the channel.
- R5: w_addr = w_base + s*K*K + ky*K + kx, taken modulo 2^WA_W. Here K = k_m1+1. In regular mode s = oc*(n_in_m1+1)+ic; in depthwise mode s is the channel.
- R6: tap_first is 1 on tap (0,0) of every kernel window. tap_last is 1 on tap (K-1,K-1) of every kernel window. For a 1x1 kernel both are 1 on the same tap.
- R7: acc_last is 1 only on the final tap of a window that ends an output accumulation. In regular mode that is the window of the last input channel. In depthwise mode it is every window.
- R8: Taps are issued one per cycle, with no gap in tap_vld, from the first tap to the last.
- R9: done is 1 for exactly one cycle, in the cycle right after the last tap. busy returns to 0 in the cycle after done.
- R10: A start seen while busy is 1, including the done cycle, is ignored. The running sequence and the idle state that follows it are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start a layer; accepted only when idle |
| mode | input | 1 | 0 = regular, 1 = depthwise |
| n_in_m1 | input | CH_W | Input channel count minus one (regular mode only) |
| n_out_m1 | input | CH_W | Output channel count minus one |
| n_blk_m1 | input | BLK_W | Spatial block count minus one |
| k_m1 | input | K_W | Kernel side minus one |
| dil_m1 | input | DIL_W | Dilation rate minus one |
| row_stride | input | FA_W | Feature address step per image row |
| blk_stride | input | FA_W | Feature address step per spatial block |
| ch_stride | input | FA_W | Feature address step per channel |
| w_base | input | WA_W | Weight address of this layer's first tap |
| busy | output | 1 | Layer in progress |
| tap_vld | output | 1 | Tap outputs valid |
| tap_first | output | 1 | First tap of a kernel window |
| tap_last | output | 1 | Last tap of a kernel window |
| acc_last | output | 1 | Last tap of an output accumulation |
| fm_addr | output | FA_W | Feature-map memory address |
| w_addr | output | WA_W | Weight memory address |
| done | output | 1 | One-cycle end-of-layer pulse |

## Verification
The main sequence is tried with several layer shapes, and each one separates a different class of fault. A regular 3x3 layer with two channels of each kind exposes swapped block and input-channel levels. A depthwise 3x3 layer at dilation 2, given a nonzero input-channel count, shows whether that count leaks into the loop or the weight index and whether the dilation scales both offsets. A 1x1 regular layer forces tap_first and tap_last onto the same tap. A 5x5 depthwise layer and a 2x2 regular layer at dilation 3 with three blocks check the kernel bounds and the block stride. Start pulses in mid-run and in the done cycle show whether the busy guard holds.

// File: rtl/conv_seq_pkg.sv
`timescale 1ns/1ps
package conv_seq_pkg;
  typedef enum logic {
    MODE_REG = 1'b0,
    MODE_DW  = 1'b1
  } conv_mode_e;

  typedef struct packed {
    logic first;   // tap (0,0) of a window
    logic last;    // final tap of a window
    logic acc;     // final tap of an output accumulation
    logic fin;     // final tap of the layer
  } tap_flags_t;
endpackage

// File: rtl/conv_seq_ctrl.sv
`timescale 1ns/1ps
module conv_seq_ctrl
  import conv_seq_pkg::*;
#(
  parameter int CH_W  = 4,
  parameter int BLK_W = 4,
  parameter int K_W   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  conv_mode_e       mode_i,
  input  logic [CH_W-1:0]  n_in_m1_i,
  input  logic [CH_W-1:0]  n_out_m1_i,
  input  logic [BLK_W-1:0] n_blk_m1_i,
  input  logic [K_W-1:0]   k_m1_i,
  input  logic             done_i,
  output logic             accept_o,
  output logic             busy_o,
  output logic             run_o,
  output conv_mode_e       mode_o,
  output logic [CH_W-1:0]  n_in_o,
  output logic [K_W-1:0]   k_o,
  output logic [CH_W-1:0]  oc_o,
  output logic [CH_W-1:0]  ic_o,
  output logic [BLK_W-1:0] blk_o,
  output logic [K_W-1:0]   ky_o,
  output logic [K_W-1:0]   kx_o,
  output tap_flags_t       flags_o
);
  logic             busy_q, run_q;
  conv_mode_e       mode_q;
  logic [CH_W-1:0]  nin_q, nout_q, oc_q, ic_q;
  logic [BLK_W-1:0] nblk_q, blk_q;
  logic [K_W-1:0]   k_q, ky_q, kx_q;

  logic accept, kx_end, ky_end, tap_end, ic_end, blk_end, oc_end;

  assign accept  = start_i & ~busy_q;
  assign kx_end  = (kx_q == k_q);
  assign ky_end  = (ky_q == k_q);
  assign tap_end = kx_end & ky_end;
  // depthwise has no input-channel level: it always counts as ended
  assign ic_end  = (mode_q == MODE_DW) || (ic_q == nin_q);
  assign blk_end = (blk_q == nblk_q);
  assign oc_end  = (oc_q == nout_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      run_q  <= 1'b0;
      mode_q <= MODE_REG;
      nin_q  <= '0;
      nout_q <= '0;
      nblk_q <= '0;
      k_q    <= '0;
      oc_q   <= '0;
      ic_q   <= '0;
      blk_q  <= '0;
      ky_q   <= '0;
      kx_q   <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      run_q  <= 1'b1;
      mode_q <= mode_i;
      nin_q  <= n_in_m1_i;
      nout_q <= n_out_m1_i;
      nblk_q <= n_blk_m1_i;
      k_q    <= k_m1_i;
      oc_q   <= '0;
      ic_q   <= '0;
      blk_q  <= '0;
      ky_q   <= '0;
      kx_q   <= '0;
    end else begin
      if (done_i) busy_q <= 1'b0;
      if (run_q) begin
        if (!kx_end) kx_q <= kx_q + 1'b1;
        else begin
          kx_q <= '0;
          if (!ky_end) ky_q <= ky_q + 1'b1;
          else begin
            ky_q <= '0;
            if (!ic_end) ic_q <= ic_q + 1'b1;
            else begin
              ic_q <= '0;
              if (!blk_end) blk_q <= blk_q + 1'b1;
              else begin
                blk_q <= '0;
                if (!oc_end) oc_q <= oc_q + 1'b1;
                else run_q <= 1'b0;
              end
            end
          end
        end
      end
    end
  end

  assign accept_o      = accept;
  assign busy_o        = busy_q;
  assign run_o         = run_q;
  assign mode_o        = mode_q;
  assign n_in_o        = nin_q;
  assign k_o           = k_q;
  assign oc_o          = oc_q;
  assign ic_o          = ic_q;
  assign blk_o         = blk_q;
  assign ky_o          = ky_q;
  assign kx_o          = kx_q;
  assign flags_o.first = (kx_q == '0) && (ky_q == '0);
  assign flags_o.last  = tap_end;
  assign flags_o.acc   = tap_end & ic_end;
  assign flags_o.fin   = tap_end & ic_end & blk_end & oc_end;

  // R1: the loop never runs outside a busy window
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> !run_q);
  // R2: the column index steps by one while inside a kernel row
  a_r2_col_step: assert property (@(posedge clk) disable iff (rst)
    run_q && !kx_end |=> kx_q == $past(kx_q) + 1'b1);
  // R9: done arrives only after the loop has stopped, and it ends busy
  a_r9_done_after_run: assert property (@(posedge clk) disable iff (rst)
    done_i |-> !run_q);
  a_r9_busy_drop: assert property (@(posedge clk) disable iff (rst)
    done_i |=> !busy_q);
  // R10: a start while busy leaves the captured layer untouched
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    busy_q && start_i |=> $stable(mode_q) && $stable(k_q) && $stable(nout_q));
endmodule

// File: rtl/conv_seq_addr.sv
`timescale 1ns/1ps
module conv_seq_addr
  import conv_seq_pkg::*;
#(
  parameter int CH_W  = 4,
  parameter int BLK_W = 4,
  parameter int K_W   = 3,
  parameter int DIL_W = 2,
  parameter int FA_W  = 16,
  parameter int WA_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept_i,
  input  logic [DIL_W-1:0] dil_m1_i,
  input  logic [FA_W-1:0]  row_stride_i,
  input  logic [FA_W-1:0]  blk_stride_i,
  input  logic [FA_W-1:0]  ch_stride_i,
  input  logic [WA_W-1:0]  w_base_i,
  input  logic             valid_i,
  input  conv_mode_e       mode_i,
  input  logic [CH_W-1:0]  n_in_i,
  input  logic [K_W-1:0]   k_i,
  input  logic [CH_W-1:0]  oc_i,
  input  logic [CH_W-1:0]  ic_i,
  input  logic [BLK_W-1:0] blk_i,
  input  logic [K_W-1:0]   ky_i,
  input  logic [K_W-1:0]   kx_i,
  input  tap_flags_t       flags_i,
  output logic             vld_o,
  output logic             first_o,
  output logic             last_o,
  output logic             acc_o,
  output logic [FA_W-1:0]  fm_addr_o,
  output logic [WA_W-1:0]  w_addr_o,
  output logic             done_o
);
  logic [DIL_W-1:0] dil_q;
  logic [FA_W-1:0]  rs_q, bs_q, cs_q;
  logic [WA_W-1:0]  wb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dil_q <= '0;
      rs_q  <= '0;
      bs_q  <= '0;
      cs_q  <= '0;
      wb_q  <= '0;
    end else if (accept_i) begin
      dil_q <= dil_m1_i;
      rs_q  <= row_stride_i;
      bs_q  <= blk_stride_i;
      cs_q  <= ch_stride_i;
      wb_q  <= w_base_i;
    end
  end

  // feature side: channel plane + block + dilated tap offset
  logic [FA_W-1:0] rate, ch_f, fm_next;
  assign rate    = FA_W'(dil_q) + 1'b1;
  assign ch_f    = (mode_i == MODE_DW) ? FA_W'(oc_i) : FA_W'(ic_i);
  assign fm_next = ch_f * cs_q + FA_W'(blk_i) * bs_q
                 + rate * FA_W'(ky_i) * rs_q + rate * FA_W'(kx_i);

  // weight side: one K*K kernel per (output, input) pair, or per channel
  logic [WA_W-1:0] kdim, ksq, wsel, w_next;
  assign kdim   = WA_W'(k_i) + 1'b1;
  assign ksq    = kdim * kdim;
  assign wsel   = (mode_i == MODE_DW) ? WA_W'(oc_i)
                : WA_W'(oc_i) * (WA_W'(n_in_i) + 1'b1) + WA_W'(ic_i);
  assign w_next = wb_q + wsel * ksq + WA_W'(ky_i) * kdim + WA_W'(kx_i);

  logic            vld_q, first_q, last_q, acc_q, fin_q, done_q;
  logic [FA_W-1:0] fm_q;
  logic [WA_W-1:0] w_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q   <= 1'b0;
      first_q <= 1'b0;
      last_q  <= 1'b0;
      acc_q   <= 1'b0;
      fin_q   <= 1'b0;
      done_q  <= 1'b0;
      fm_q    <= '0;
      w_q     <= '0;
    end else begin
      vld_q   <= valid_i;
      first_q <= valid_i & flags_i.first;
      last_q  <= valid_i & flags_i.last;
      acc_q   <= valid_i & flags_i.acc;
      fin_q   <= valid_i & flags_i.fin;
      done_q  <= vld_q & fin_q;
      if (valid_i) begin
        fm_q <= fm_next;
        w_q  <= w_next;
      end
    end
  end

  assign vld_o     = vld_q;
  assign first_o   = first_q;
  assign last_o    = last_q;
  assign acc_o     = acc_q;
  assign fm_addr_o = fm_q;
  assign w_addr_o  = w_q;
  assign done_o    = done_q;

  // R6: a window that is not the layer's last is followed by a new window
  a_r6_first_after_last: assert property (@(posedge clk) disable iff (rst)
    vld_q && last_q && !fin_q |=> first_q);
  // R7: in depthwise mode every window closes an accumulation
  a_r7_dw_acc: assert property (@(posedge clk) disable iff (rst)
    vld_q && last_q && mode_i == MODE_DW |-> acc_q);
  // R8: no bubble between the first and the last tap
  a_r8_no_gap: assert property (@(posedge clk) disable iff (rst)
    vld_q && !fin_q |=> vld_q);
  // R9: done is a single-cycle pulse with no tap beside it
  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  a_r9_done_quiet: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !vld_q);
endmodule

// File: rtl/conv_seq.sv
`timescale 1ns/1ps
module conv_seq
  import conv_seq_pkg::*;
#(
  parameter int CH_W  = 4,
  parameter int BLK_W = 4,
  parameter int K_W   = 3,
  parameter int DIL_W = 2,
  parameter int FA_W  = 16,
  parameter int WA_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             mode,
  input  logic [CH_W-1:0]  n_in_m1,
  input  logic [CH_W-1:0]  n_out_m1,
  input  logic [BLK_W-1:0] n_blk_m1,
  input  logic [K_W-1:0]   k_m1,
  input  logic [DIL_W-1:0] dil_m1,
  input  logic [FA_W-1:0]  row_stride,
  input  logic [FA_W-1:0]  blk_stride,
  input  logic [FA_W-1:0]  ch_stride,
  input  logic [WA_W-1:0]  w_base,
  output logic             busy,
  output logic             tap_vld,
  output logic             tap_first,
  output logic             tap_last,
  output logic             acc_last,
  output logic [FA_W-1:0]  fm_addr,
  output logic [WA_W-1:0]  w_addr,
  output logic             done
);
  logic             accept, run, done_int;
  conv_mode_e       mode_q;
  logic [CH_W-1:0]  nin_q, oc, ic;
  logic [K_W-1:0]   k_q, ky, kx;
  logic [BLK_W-1:0] blk;
  tap_flags_t       flags;

  conv_seq_ctrl #(.CH_W(CH_W), .BLK_W(BLK_W), .K_W(K_W)) u_ctrl (
    .clk(clk), .rst(rst), .start_i(start), .mode_i(conv_mode_e'(mode)),
    .n_in_m1_i(n_in_m1), .n_out_m1_i(n_out_m1), .n_blk_m1_i(n_blk_m1),
    .k_m1_i(k_m1), .done_i(done_int), .accept_o(accept), .busy_o(busy),
    .run_o(run), .mode_o(mode_q), .n_in_o(nin_q), .k_o(k_q),
    .oc_o(oc), .ic_o(ic), .blk_o(blk), .ky_o(ky), .kx_o(kx), .flags_o(flags)
  );

  conv_seq_addr #(.CH_W(CH_W), .BLK_W(BLK_W), .K_W(K_W), .DIL_W(DIL_W),
                  .FA_W(FA_W), .WA_W(WA_W)) u_addr (
    .clk(clk), .rst(rst), .accept_i(accept), .dil_m1_i(dil_m1),
    .row_stride_i(row_stride), .blk_stride_i(blk_stride),
    .ch_stride_i(ch_stride), .w_base_i(w_base), .valid_i(run),
    .mode_i(mode_q), .n_in_i(nin_q), .k_i(k_q), .oc_i(oc), .ic_i(ic),
    .blk_i(blk), .ky_i(ky), .kx_i(kx), .flags_i(flags),
    .vld_o(tap_vld), .first_o(tap_first), .last_o(tap_last),
    .acc_o(acc_last), .fm_addr_o(fm_addr), .w_addr_o(w_addr),
    .done_o(done_int)
  );

  assign done = done_int;
endmodule

// File: tb/conv_seq_tb.sv
`timescale 1ns/1ps
module conv_seq_tb;
  typedef struct packed {
    logic        mode;
    logic [3:0]  nin_m1;
    logic [3:0]  nout_m1;
    logic [3:0]  nblk_m1;
    logic [2:0]  k_m1;
    logic [1:0]  dil_m1;
    logic [15:0] rs;
    logic [15:0] bs;
    logic [15:0] cs;
    logic [15:0] wb;
  } cfg_t;

  localparam int NCFG = 5;
  localparam cfg_t CFGS [NCFG] = '{
    '{1'b0, 4'd1, 4'd1, 4'd1, 3'd2, 2'd0, 16'd16, 16'd4,  16'd256,  16'd100},
    '{1'b1, 4'd7, 4'd2, 4'd1, 3'd2, 2'd1, 16'd20, 16'd8,  16'd512,  16'd500},
    '{1'b0, 4'd3, 4'd1, 4'd0, 3'd0, 2'd0, 16'd10, 16'd2,  16'd64,   16'd0},
    '{1'b1, 4'd0, 4'd1, 4'd0, 3'd4, 2'd0, 16'd32, 16'd0,  16'd1024, 16'd40},
    '{1'b0, 4'd0, 4'd0, 4'd2, 3'd1, 2'd2, 16'd50, 16'd7,  16'd0,    16'd9000}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, mode = 1'b0;
  logic [3:0] n_in_m1 = '0, n_out_m1 = '0, n_blk_m1 = '0;
  logic [2:0] k_m1 = '0;
  logic [1:0] dil_m1 = '0;
  logic [15:0] row_stride = '0, blk_stride = '0, ch_stride = '0, w_base = '0;
  logic busy, tap_vld, tap_first, tap_last, acc_last, done;
  logic [15:0] fm_addr, w_addr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  conv_seq u_dut (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .n_in_m1(n_in_m1),
    .n_out_m1(n_out_m1), .n_blk_m1(n_blk_m1), .k_m1(k_m1), .dil_m1(dil_m1),
    .row_stride(row_stride), .blk_stride(blk_stride), .ch_stride(ch_stride),
    .w_base(w_base), .busy(busy), .tap_vld(tap_vld), .tap_first(tap_first),
    .tap_last(tap_last), .acc_last(acc_last), .fm_addr(fm_addr),
    .w_addr(w_addr), .done(done)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000 && !finished) begin
      errors = errors + 1;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 100000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input cfg_t c);
    mode = c.mode; n_in_m1 = c.nin_m1; n_out_m1 = c.nout_m1;
    n_blk_m1 = c.nblk_m1; k_m1 = c.k_m1; dil_m1 = c.dil_m1;
    row_stride = c.rs; blk_stride = c.bs; ch_stride = c.cs; w_base = c.wb;
  endtask

  task automatic run_cfg(input cfg_t c, input int poke_at);
    int kd, rate, nic, idx, chan, wsel, efm, ew;
    bit ef, el, ea;
    kd   = int'(c.k_m1) + 1;
    rate = int'(c.dil_m1) + 1;
    nic  = c.mode ? 1 : int'(c.nin_m1) + 1;
    apply(c);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R1 busy after start", int'(busy), 1);
    chk(tap_vld == 1'b0, "R1 no tap yet", int'(tap_vld), 0);
    @(negedge clk);
    idx = 0;
    for (int oc = 0; oc <= int'(c.nout_m1); oc++)
      for (int blk = 0; blk <= int'(c.nblk_m1); blk++)
        for (int ic = 0; ic < nic; ic++)
          for (int ky = 0; ky < kd; ky++)
            for (int kx = 0; kx < kd; kx++) begin
              chan = c.mode ? oc : ic;
              wsel = c.mode ? oc : oc * (int'(c.nin_m1) + 1) + ic;
              efm  = (chan * int'(c.cs) + blk * int'(c.bs)
                     + rate * ky * int'(c.rs) + rate * kx) & 16'hFFFF;
              ew   = (int'(c.wb) + wsel * kd * kd + ky * kd + kx) & 16'hFFFF;
              ef   = (ky == 0) && (kx == 0);
              el   = (ky == kd - 1) && (kx == kd - 1);
              ea   = el && (c.mode || ic == nic - 1);
              chk(tap_vld == 1'b1, "R8 tap_vld", int'(tap_vld), 1);
              chk(int'(fm_addr) == efm, c.mode ? "R3/R4 fm_addr" : "R2/R4 fm_addr",
                  int'(fm_addr), efm);
              chk(int'(w_addr) == ew, "R5 w_addr", int'(w_addr), ew);
              chk(tap_first == ef && tap_last == el, "R6 first/last",
                  int'({tap_first, tap_last}), int'({ef, el}));
              chk(acc_last == ea, "R7 acc_last", int'(acc_last), int'(ea));
              // R10: pulse start with other settings in mid-run
              if (idx == poke_at) begin
                start = 1'b1; mode = ~c.mode; k_m1 = 3'd0; n_out_m1 = 4'd9;
              end else if (idx == poke_at + 1) begin
                start = 1'b0; apply(c);
              end
              idx++;
              @(negedge clk);
            end
    start = 1'b0;
    apply(c);
    chk(done == 1'b1, "R9 done after last tap", int'(done), 1);
    chk(tap_vld == 1'b0, "R9 no tap with done", int'(tap_vld), 0);
    chk(busy == 1'b1, "R9 busy during done", int'(busy), 1);
    start = 1'b1;   // R10: start during the done cycle must be ignored
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, "R9 done single cycle", int'(done), 0);
    chk(busy == 1'b0, "R9 busy dropped", int'(busy), 0);
    @(negedge clk);
    @(negedge clk);
    chk(busy == 1'b0 && tap_vld == 1'b0, "R10 start in done cycle ignored",
        int'({busy, tap_vld}), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && tap_vld == 1'b0 && done == 1'b0, "R1 reset outputs",
        int'({busy, tap_vld, done}), 0);
    chk(tap_first == 1'b0 && tap_last == 1'b0 && acc_last == 1'b0, "R1 reset flags",
        int'({tap_first, tap_last, acc_last}), 0);
    start = 1'b1;   // R1: start under reset is not taken
    @(negedge clk);
    start = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R1 idle after reset", int'(busy), 0);

    for (int i = 0; i < NCFG; i++) run_cfg(CFGS[i], 3);

    // back-to-back: a new start right after busy drops is accepted
    run_cfg(CFGS[2], -5);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule